// File: doc/BRIEF.md
# Flash Bus Write Guard and Reset Sequencer

This block is the front-end control logic of a byte-wide parallel flash device. It sits between the external chip-enable, output-enable, write-enable and hardware-reset pins and the internal command state machine. It decides which bus activity counts as a real write cycle. It runs the timed hardware-reset sequence and gates the data-output drivers. It asks the command machine to return to read mode after power-up, after an accepted reset and on entry into supply lockout.

All pins are asynchronous. Each pin passes through a two-stage synchronizer clocked by a fast sampling clock. The three bus controls then pass through a per-pin stability filter that rejects short pulses. Every time rule counts cycles of the sampling clock, with the counts set by parameters. A supply-voltage-OK comparator result arrives as a digital input. The block produces four things:
- a one-cycle qualified write strobe, together with the captured address and data;
- a read-mode request pulse;
- a command-halt level;
- a status bit that records an aborted program or erase.

Top module: `flash_bus_guard`

## Requirements
- R1: A write cycle starts when, after filtering, `ce_n` and `we_n` are both low while `oe_n` is high. When that cycle ends because `ce_n` or `we_n` rises while `oe_n` is still high, `wr_strobe` goes high for exactly one cycle. In that same cycle, `wr_addr` and `wr_data` present the `addr` and `wdata` values sampled at the end of the cycle.
- R2: `oe_n` held low or `ce_n` held high for the whole of a write-enable pulse produces no `wr_strobe`.
- R3: A low pulse shorter than GLITCH_CYC sample cycles on `ce_n`, `we_n` or `oe_n` has no effect. A level held for GLITCH_CYC cycles or more is accepted.
- R4: While `rst_n` is low, `wr_strobe` and `to_read` are low and `cmd_halt` is high. After release, `to_read` pulses once. If the pins already sit in the write state (CE low, WE low, OE high) at power-up, the first end of that cycle yields no strobe.
- R5: A low pulse on `hwrst_n` shorter than RST_MIN_CYC cycles produces no `to_read` and does not set `op_aborted`.
- R6: `standby` is high and `dout_en` is low from the second clock edge after `hwrst_n` falls, for as long as it stays low.
- R7: When `hwrst_n` stays low for RST_MIN_CYC cycles, the reset is accepted and `cmd_halt` rises. `to_read` then pulses exactly RST_RDY_CYC+2 cycles after the pin fell.
- R8: Outside reset, `dout_en` is high when `ce_n` and `oe_n` are both low. After an accepted reset, `dout_en` first returns RST_REC_CYC+3 cycles after `hwrst_n` rises.
- R9: While `vdd_ok` is low, `cmd_halt` is high and no `wr_strobe` is issued. Entering lockout pulses `to_read`. A cycle that began during lockout gives no strobe, even if it ends after the supply returns.
- R10: `op_aborted` is set when a reset is accepted, or lockout is entered, while `busy` is high. It is cleared by the next `wr_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| hwrst_n | input | 1 | Hardware reset pin, active low |
| vdd_ok | input | 1 | Supply above lockout level |
| busy | input | 1 | Program or erase running in the core |
| addr | input | AW | Address bus |
| wdata | input | DW | Data bus, write direction |
| wr_strobe | output | 1 | Qualified write, one cycle |
| wr_addr | output | AW | Address captured with the strobe |
| wr_data | output | DW | Data captured with the strobe |
| to_read | output | 1 | One-cycle request to enter read mode |
| cmd_halt | output | 1 | Command register disabled, operation aborted |
| standby | output | 1 | Reset pin low, device in standby |
| dout_en | output | 1 | Data output drivers enabled |
| op_aborted | output | 1 | Program or erase aborted by reset or lockout |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe is always a single-cycle pulse;
- no strobe follows a cycle in which writing was disallowed;
- a filtered pin only ever takes a value its synchronized input has just shown;
- an accepted reset halts the command machine at once;
- the halt only ends by entering recovery;
- lockout entry is always followed by a read-mode request.

Other behaviour can only be shown by the bench's pin sequences: the exact pulse widths that separate a glitch from a real edge, the reset-to-read latency, the recovery delay, power-up with the pins already in the write state, and a write that straddles a supply return.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [2:0] {
    RS_IDLE  = 3'd0,
    RS_LOW   = 3'd1,
    RS_HOLD  = 3'd2,
    RS_HELD  = 3'd3,
    RS_RECOV = 3'd4
  } rst_st_e;

  localparam int PIN_CE = 0;
  localparam int PIN_OE = 1;
  localparam int PIN_WE = 2;
  localparam int NPIN   = 3;

  // Reset value of the bus pins as seen after power-up: the write state,
  // so that a cycle already open at power-up can never be armed.
  localparam logic [NPIN-1:0] PIN_RST = 3'b010;

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/fe_deglitch.sv
module fe_deglitch #(
  parameter int   CYC     = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic s_i,
  output logic f_o
);

  localparam int CW = $clog2(CYC + 1);

  logic          f_q, f_d;
  logic [CW-1:0] c_q, c_d;

  always_comb begin
    f_d = f_q;
    c_d = '0;
    if (s_i != f_q) begin
      if (c_q == CW'(CYC - 1)) begin
        f_d = s_i;
      end else begin
        c_d = c_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q <= RST_VAL;
      c_q <= '0;
    end else begin
      f_q <= f_d;
      c_q <= c_d;
    end
  end

  assign f_o = f_q;

  // R3
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (f_q != $past(f_q)) |-> (f_q == $past(s_i)));

endmodule

// File: rtl/fe_rst_seq.sv
module fe_rst_seq
  import flash_guard_pkg::*;
#(
  parameter int MIN_CYC = 8,
  parameter int RDY_CYC = 40,
  parameter int REC_CYC = 6
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin_s_i,
  output logic accept_o,
  output logic rdy_o,
  output logic halt_o,
  output logic idle_o
);

  localparam int CMAX0 = (RDY_CYC > REC_CYC) ? RDY_CYC : REC_CYC;
  localparam int CMAX  = (CMAX0 > MIN_CYC) ? CMAX0 : MIN_CYC;
  localparam int CW    = $clog2(CMAX + 1);

  rst_st_e       st_q, st_d;
  logic [CW-1:0] c_q, c_d;

  always_comb begin
    st_d     = st_q;
    c_d      = c_q;
    accept_o = 1'b0;
    rdy_o    = 1'b0;
    unique case (st_q)
      RS_IDLE: begin
        if (!pin_s_i) begin
          st_d = RS_LOW;
          c_d  = CW'(1);
        end
      end
      RS_LOW: begin
        if (pin_s_i) begin
          st_d = RS_IDLE;
          c_d  = '0;
        end else if (c_q == CW'(MIN_CYC - 1)) begin
          st_d     = RS_HOLD;
          c_d      = CW'(MIN_CYC);
          accept_o = 1'b1;
        end else begin
          c_d = c_q + 1'b1;
        end
      end
      RS_HOLD: begin
        if (c_q == CW'(RDY_CYC - 1)) begin
          st_d  = RS_HELD;
          c_d   = '0;
          rdy_o = 1'b1;
        end else begin
          c_d = c_q + 1'b1;
        end
      end
      RS_HELD: begin
        if (pin_s_i) begin
          st_d = RS_RECOV;
          c_d  = '0;
        end
      end
      RS_RECOV: begin
        if (!pin_s_i) begin
          st_d = RS_LOW;
          c_d  = CW'(1);
        end else if (c_q == CW'(REC_CYC - 1)) begin
          st_d = RS_IDLE;
          c_d  = '0;
        end else begin
          c_d = c_q + 1'b1;
        end
      end
      default: begin
        st_d = RS_IDLE;
        c_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RS_IDLE;
      c_q  <= '0;
    end else begin
      st_q <= st_d;
      c_q  <= c_d;
    end
  end

  assign halt_o = (st_q == RS_HOLD) || (st_q == RS_HELD);
  assign idle_o = (st_q == RS_IDLE);

  // R7
  accept_halts_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    accept_o |=> halt_o);

  // R8
  halt_ends_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(halt_o) |-> (st_q == RS_RECOV));

endmodule

// File: rtl/fe_wr_qual.sv
module fe_wr_qual #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          ce_f_i,
  input  logic          oe_f_i,
  input  logic          we_f_i,
  input  logic          write_ok_i,
  input  logic          abort_evt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          strobe_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          aborted_o
);

  logic          cond;
  logic          cond_q;
  logic          armed_q, armed_d;
  logic          strobe_q, strobe_d;
  logic          abt_q, abt_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign cond = !ce_f_i && !we_f_i && oe_f_i;

  always_comb begin
    armed_d  = armed_q;
    strobe_d = 1'b0;
    if (!write_ok_i) begin
      armed_d = 1'b0;
    end else if (cond && !cond_q) begin
      armed_d = 1'b1;
    end else if (armed_q && !cond) begin
      armed_d  = 1'b0;
      strobe_d = oe_f_i;
    end
    if (abort_evt_i) begin
      abt_d = 1'b1;
    end else if (strobe_d) begin
      abt_d = 1'b0;
    end else begin
      abt_d = abt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q   <= 1'b1;
      armed_q  <= 1'b0;
      strobe_q <= 1'b0;
      abt_q    <= 1'b0;
    end else begin
      cond_q   <= cond;
      armed_q  <= armed_d;
      strobe_q <= strobe_d;
      abt_q    <= abt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (strobe_d) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign strobe_o  = strobe_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign aborted_o = abt_q;

  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);

  // R9
  no_strobe_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !write_ok_i |=> !strobe_q);

  // R10
  abort_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    abort_evt_i |=> abt_q);

endmodule

// File: rtl/flash_bus_guard.sv
module flash_bus_guard
  import flash_guard_pkg::*;
#(
  parameter int AW          = 18,
  parameter int DW          = 8,
  parameter int GLITCH_CYC  = 3,
  parameter int RST_MIN_CYC = 8,
  parameter int RST_RDY_CYC = 40,
  parameter int RST_REC_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hwrst_n,
  input  logic          vdd_ok,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          to_read,
  output logic          cmd_halt,
  output logic          standby,
  output logic          dout_en,
  output logic          op_aborted
);

  localparam int               NSYNC    = NPIN + 2;
  localparam logic [NSYNC-1:0] SYNC_RST = {1'b0, 1'b1, PIN_RST};

  // Power-on reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_ni = rs2_q;

  logic [NSYNC-1:0] raw, synced;
  logic [NPIN-1:0]  pin_f;
  logic             vdd_s, rst_s;

  assign raw   = {vdd_ok, hwrst_n, we_n, oe_n, ce_n};
  assign vdd_s = synced[NPIN+1];
  assign rst_s = synced[NPIN];

  fe_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_flt
    fe_deglitch #(.CYC(GLITCH_CYC), .RST_VAL(PIN_RST[i])) u_flt (
      .clk(clk), .rst_ni(rst_ni), .s_i(synced[i]), .f_o(pin_f[i])
    );
  end

  logic rs_accept, rs_rdy, rs_halt, rs_idle;

  fe_rst_seq #(
    .MIN_CYC(RST_MIN_CYC), .RDY_CYC(RST_RDY_CYC), .REC_CYC(RST_REC_CYC)
  ) u_rst (
    .clk(clk), .rst_ni(rst_ni), .pin_s_i(rst_s),
    .accept_o(rs_accept), .rdy_o(rs_rdy), .halt_o(rs_halt), .idle_o(rs_idle)
  );

  logic vdd_q, pu_q, to_read_q;
  logic vdd_fall, write_ok, abort_evt;

  assign vdd_fall  = vdd_q && !vdd_s;
  assign write_ok  = vdd_s && rs_idle;
  assign abort_evt = busy && (rs_accept || vdd_fall);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vdd_q     <= 1'b0;
      pu_q      <= 1'b1;
      to_read_q <= 1'b0;
    end else begin
      vdd_q     <= vdd_s;
      pu_q      <= 1'b0;
      to_read_q <= pu_q || vdd_fall || rs_rdy;
    end
  end

  fe_wr_qual #(.AW(AW), .DW(DW)) u_wq (
    .clk(clk), .rst_ni(rst_ni),
    .ce_f_i(pin_f[PIN_CE]), .oe_f_i(pin_f[PIN_OE]), .we_f_i(pin_f[PIN_WE]),
    .write_ok_i(write_ok), .abort_evt_i(abort_evt),
    .addr_i(addr), .data_i(wdata),
    .strobe_o(wr_strobe), .addr_o(wr_addr), .data_o(wr_data),
    .aborted_o(op_aborted)
  );

  assign to_read  = to_read_q;
  assign cmd_halt = rs_halt || !vdd_s;
  assign standby  = !rst_s;
  assign dout_en  = rs_idle && rst_s && !pin_f[PIN_CE] && !pin_f[PIN_OE];

  // R9
  lockout_requests_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    vdd_fall |=> to_read_q);

endmodule

// File: tb/sim_flash_bus_guard.sv
module sim_flash_bus_guard;

  localparam int CLK_P = 10;
  localparam int AW    = 18;
  localparam int DW    = 8;
  localparam int G     = 3;
  localparam int RMIN  = 8;
  localparam int RRDY  = 40;
  localparam int RREC  = 6;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, hwrst_n, vdd_ok, busy;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic wr_strobe, to_read, cmd_halt, standby, dout_en, op_aborted;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #(CLK_P / 2) clk = ~clk;

  flash_bus_guard #(
    .AW(AW), .DW(DW), .GLITCH_CYC(G),
    .RST_MIN_CYC(RMIN), .RST_RDY_CYC(RRDY), .RST_REC_CYC(RREC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hwrst_n(hwrst_n), .vdd_ok(vdd_ok), .busy(busy), .addr(addr), .wdata(wdata),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
    .to_read(to_read), .cmd_halt(cmd_halt), .standby(standby),
    .dout_en(dout_en), .op_aborted(op_aborted)
  );

  int n_chk = 0, n_bad = 0;
  int n_str = 0, n_tr = 0;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;
  bit done = 0;

  always @(negedge clk) begin
    if (wr_strobe === 1'b1) begin
      n_str++;
      last_a = wr_addr;
      last_d = wr_data;
    end
    if (to_read === 1'b1) n_tr++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_strobe(input int v, input int wlen, input bit allowed);
    return allowed && (v < 2) && (wlen >= G);
  endfunction

  // v: 0 WE ends cycle, 1 CE ends cycle, 2 OE held low, 3 CE held high
  task automatic do_cycle(input int v, input int wlen, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit allowed, input string req);
    int n0 = n_str;
    bit e = exp_strobe(v, wlen, allowed);
    addr = a; wdata = d;
    case (v)
      0: begin ce_n = 0; tick(G + 4); we_n = 0; tick(wlen); we_n = 1; tick(G + 6); ce_n = 1; end
      1: begin we_n = 0; tick(G + 4); ce_n = 0; tick(wlen); ce_n = 1; tick(G + 6); we_n = 1; end
      2: begin oe_n = 0; ce_n = 0; tick(G + 4); we_n = 0; tick(wlen); we_n = 1;
               tick(G + 6); ce_n = 1; tick(G + 4); oe_n = 1; end
      default: begin we_n = 0; tick(wlen); we_n = 1; end
    endcase
    tick(G + 6);
    chk(req, n_str - n0, int'(e));
    if (e) begin
      chk({req, " addr"}, int'(last_a), int'(a));
      chk({req, " data"}, int'(last_d), int'(d));
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
    end
  end

  initial begin
    int got, n0;
    void'($urandom(32'd4711));
    // power up with pins already in the write state
    rst_n = 0; ce_n = 0; we_n = 0; oe_n = 1; hwrst_n = 1; vdd_ok = 1; busy = 0;
    addr = '0; wdata = '0;
    tick(4);
    chk("R4 reset strobe", int'(wr_strobe), 0);
    chk("R4 reset to_read", int'(to_read), 0);
    chk("R4 reset halt", int'(cmd_halt), 1);
    chk("R10 reset aborted", int'(op_aborted), 0);
    rst_n = 1;
    tick(20);
    chk("R4 power-up read request", n_tr, 1);
    we_n = 1;
    tick(20);
    chk("R4 first WE rise ignored", n_str, 0);
    ce_n = 1;
    tick(10);
    chk("R9 halt clear with supply", int'(cmd_halt), 0);

    // directed glitch and inhibit corners
    do_cycle(0, G - 1, 18'h00011, 8'h11, 1, "R3 short WE");
    do_cycle(0, G, 18'h00022, 8'h22, 1, "R3 WE at threshold");
    do_cycle(1, G - 1, 18'h00033, 8'h33, 1, "R3 short CE");
    do_cycle(2, G + 4, 18'h00044, 8'h44, 1, "R2 OE low");
    do_cycle(3, G + 4, 18'h00055, 8'h55, 1, "R2 CE high");

    // OE glitch inside a write must not break it
    n0 = n_str;
    addr = 18'h2A5A5; wdata = 8'hC3;
    ce_n = 0; tick(G + 4); we_n = 0; tick(G + 4);
    oe_n = 0; tick(G - 1); oe_n = 1; tick(G + 4);
    we_n = 1; tick(G + 6); ce_n = 1; tick(G + 6);
    chk("R3 OE glitch ignored", n_str - n0, 1);
    chk("R1 addr after OE glitch", int'(last_a), int'(18'h2A5A5));

    // constrained random cycles
    for (int i = 0; i < 40; i++) begin
      do_cycle(int'($urandom % 4), 1 + int'($urandom % (G + 3)),
               AW'($urandom), DW'($urandom), 1, "R1 random cycle");
    end

    // read enable and short reset pulse
    ce_n = 0; oe_n = 0; tick(G + 6);
    chk("R8 read enable", int'(dout_en), 1);
    busy = 1; n0 = n_tr;
    hwrst_n = 0; tick(2);
    chk("R6 standby on short pulse", int'(standby), 1);
    tick(RMIN - 3); hwrst_n = 1;
    tick(RRDY + 10);
    chk("R5 no read request", n_tr - n0, 0);
    chk("R5 no abort", int'(op_aborted), 0);
    chk("R5 reads resume", int'(dout_en), 1);

    // accepted reset with operation running
    got = 0;
    hwrst_n = 0;
    for (int k = 1; k <= RRDY + 10; k++) begin
      tick(1);
      if (k == 1) chk("R6 standby not yet", int'(standby), 0);
      if (k == 2) begin
        chk("R6 standby", int'(standby), 1);
        chk("R6 outputs off", int'(dout_en), 0);
      end
      if (to_read && got == 0) got = k;
    end
    chk("R7 read request latency", got, RRDY + 2);
    chk("R7 halt", int'(cmd_halt), 1);
    chk("R10 abort by reset", int'(op_aborted), 1);
    busy = 0;
    got = 0;
    hwrst_n = 1;
    for (int k = 1; k <= RREC + 10; k++) begin
      tick(1);
      if (dout_en && got == 0) got = k;
    end
    chk("R8 recovery delay", got, RREC + 3);
    chk("R7 halt released", int'(cmd_halt), 0);
    oe_n = 1; ce_n = 1; tick(G + 6);

    do_cycle(0, G + 2, 18'h01234, 8'h5A, 1, "R10 write after reset");
    chk("R10 flag cleared", int'(op_aborted), 0);

    // supply lockout
    busy = 1; n0 = n_tr;
    vdd_ok = 0; tick(6);
    chk("R9 lockout read request", n_tr - n0, 1);
    chk("R9 lockout halt", int'(cmd_halt), 1);
    chk("R10 abort by lockout", int'(op_aborted), 1);
    busy = 0;
    do_cycle(0, G + 2, 18'h00777, 8'h77, 0, "R9 write in lockout");
    n0 = n_str;
    ce_n = 0; tick(G + 4); we_n = 0; tick(G + 4);
    vdd_ok = 1; tick(10);
    we_n = 1; tick(G + 6); ce_n = 1; tick(G + 6);
    chk("R9 straddling cycle", n_str - n0, 0);
    chk("R9 halt released", int'(cmd_halt), 0);
    do_cycle(1, G + 1, 18'h3FFFF, 8'hFF, 1, "R1 write after supply return");
    chk("R10 flag cleared again", int'(op_aborted), 0);

    done = 1;
    summary();
  end

endmodule